// File: doc/BRIEF.md
# Byte-Stream Parallel Bit-Bang Port

This block sits between a host byte stream and an 8-bit general-purpose pin bank. Bytes that arrive on a ready/valid input are written to an output latch that drives the pins. Each pin is an output or an input according to a direction mask, and only output pins are driven. A registered mode selects one of three behaviours: off, paced (asynchronous), or lock-step (synchronous).

In paced mode a byte is taken only in a cycle where the external rate tick is high. No data goes back to the host. In lock-step mode the rate tick is not used. Each accepted byte first captures the current pin state, which is the pre-write value, and then overwrites the latch. The captured value is queued in a one-entry return slot that feeds a ready/valid output. As a result, returned data trails written data by one byte, and the port stalls whenever the return slot cannot take a new value.

Top module: `bitbang_port`

## Requirements
- R1: After reset, pin_oe is 0x00, pin_o is 0xFF, ret_valid is 0 and cmd_ready is 0.
- R2: A mode code of 0x01 selects paced mode and a code of 0x04 selects lock-step mode. Any other code means off. While off, cmd_ready stays 0 and pin_oe is 0x00.
- R3: While paced or lock-step mode is active, pin_oe equals dir_mask, where bit value 1 marks a pin as an output.
- R4: In paced mode a byte is accepted only in a cycle where cmd_valid and rate_tick are both high. pin_o shows the new byte from the next cycle on.
- R5: pin_o keeps its last value in every cycle in which no byte is accepted.
- R6: In lock-step mode a byte is accepted without any rate tick whenever the return slot has room. pin_o shows the byte from the next cycle on.
- R7: The value returned for an accepted lock-step byte is taken before the write. Output pins give the latch value, and input pins give pin_i after a two-flop synchronizer.
- R8: Each accepted lock-step byte produces exactly one returned byte. ret_valid and ret_data hold steady until ret_ready is high.
- R9: While the return slot is full and ret_ready is low, cmd_ready is 0 in lock-step mode, and pin_o does not change.
- R10: Paced mode never raises ret_valid.
- R11: A new mode code is applied only in a cycle in which no byte is accepted. A mode change leaves the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_code | input | 8 | Requested mode code |
| dir_mask | input | 8 | Per-pin direction, 1 = output |
| rate_tick | input | 1 | Pacing strobe for paced mode |
| cmd_valid | input | 1 | Host byte available |
| cmd_ready | output | 1 | Byte accepted this cycle when valid |
| cmd_data | input | 8 | Host byte |
| ret_valid | output | 1 | Returned sample available |
| ret_ready | input | 1 | Host takes returned sample |
| ret_data | output | 8 | Returned sample |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output latch |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench runs the one-byte lag in lock-step mode, including a repeated final byte. It also uses mixed direction masks, so each returned byte must combine latch bits and synchronized input bits correctly. A design that sampled after the write, or that ignored the mask, would return the wrong byte.

Paced mode is held with a pending byte and no tick, and the latch must not move during that time. The return slot is filled with ret_ready low to show the stall: a design without back-pressure would overwrite the pending sample or move the pins. A switch from paced to lock-step mode must return the byte latched in paced mode, which a design that reset the latch on a mode change would lose.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int unsigned PIN_W  = 8;
    localparam int unsigned CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_PACED = 8'h01;
    localparam logic [CODE_W-1:0] CODE_LOCK  = 8'h04;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_PACED = 2'd1,
        MODE_LOCK  = 2'd2
    } bb_mode_e;

    function automatic bb_mode_e decode_mode(input logic [CODE_W-1:0] code);
        if (code == CODE_PACED)     return MODE_PACED;
        else if (code == CODE_LOCK) return MODE_LOCK;
        else                        return MODE_OFF;
    endfunction
endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bb_mode_ctl.sv
module bb_mode_ctl
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              busy_i,
    output bb_mode_e          mode_o
);
    bb_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!busy_i) mode_d = decode_mode(code_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    // R11
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(mode_q));
endmodule

// File: rtl/bb_engine.sv
module bb_engine
    import bb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bb_mode_e         mode_i,
    input  logic [PIN_W-1:0] dir_i,
    input  logic             tick_i,
    input  logic             cmd_valid_i,
    output logic             cmd_ready_o,
    input  logic [PIN_W-1:0] cmd_data_i,
    output logic             ret_valid_o,
    input  logic             ret_ready_i,
    output logic [PIN_W-1:0] ret_data_o,
    input  logic [PIN_W-1:0] pin_sync_i,
    output logic [PIN_W-1:0] latch_o,
    output logic             accept_o
);
    typedef struct packed {
        logic [PIN_W-1:0] latch;
        logic             rvalid;
        logic [PIN_W-1:0] rdata;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic slot_free, ready, accept;

    always_comb begin
        st_d      = st_q;
        slot_free = !st_q.rvalid || ret_ready_i;
        unique case (mode_i)
            MODE_PACED: ready = tick_i;
            MODE_LOCK:  ready = slot_free;
            default:    ready = 1'b0;
        endcase
        accept = cmd_valid_i && ready;

        if (st_q.rvalid && ret_ready_i) st_d.rvalid = 1'b0;
        if (accept) begin
            if (mode_i == MODE_LOCK) begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = (pin_sync_i & ~dir_i) | (st_q.latch & dir_i);
            end
            st_d.latch = cmd_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch  <= '1;
            st_q.rvalid <= 1'b0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready_o = ready;
    assign ret_valid_o = st_q.rvalid;
    assign ret_data_o  = st_q.rdata;
    assign latch_o     = st_q.latch;
    assign accept_o    = accept;

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |-> !cmd_ready_o);
    // R4
    paced_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PACED && cmd_valid_i && cmd_ready_o) |-> tick_i);
    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_i && cmd_ready_o) |=> $stable(latch_o));
    // R8
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_o && !ret_ready_i) |=> (ret_valid_o && $stable(ret_data_o)));
    // R8
    ret_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LOCK && cmd_valid_i && cmd_ready_o) |=> ret_valid_o);
    // R9
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LOCK && ret_valid_o && !ret_ready_i) |-> !cmd_ready_o);
    // R10
    paced_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PACED && !ret_valid_o) |=> !ret_valid_o);
endmodule

// File: rtl/bitbang_port.sv
module bitbang_port
    import bb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] mode_code,
    input  logic [7:0] dir_mask,
    input  logic       rate_tick,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_data,
    output logic       ret_valid,
    input  logic       ret_ready,
    output logic [7:0] ret_data,
    input  logic [7:0] pin_i,
    output logic [7:0] pin_o,
    output logic [7:0] pin_oe
);
    localparam int unsigned SYNC_STAGES = 2;

    bb_mode_e         mode;
    logic             accept;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] latch;

    bb_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
    );

    bb_mode_ctl i_mode (
        .clk(clk), .rst_n(rst_n), .code_i(mode_code),
        .busy_i(accept), .mode_o(mode)
    );

    bb_engine i_engine (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir_mask),
        .tick_i(rate_tick), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_data_i(cmd_data), .ret_valid_o(ret_valid), .ret_ready_i(ret_ready),
        .ret_data_o(ret_data), .pin_sync_i(pin_sync), .latch_o(latch),
        .accept_o(accept)
    );

    assign pin_o  = latch;
    assign pin_oe = (mode == MODE_OFF) ? '0 : dir_mask;

    // R3
    oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_mask) == '0);
endmodule

// File: tb/test_bitbang_port.sv
module test_bitbang_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] mode_code = 8'h00, dir_mask = 8'h00, cmd_data = 8'h00, pin_i = 8'h00;
    logic rate_tick = 1'b0, cmd_valid = 1'b0, ret_ready = 1'b1;
    logic cmd_ready, ret_valid;
    logic [7:0] ret_data, pin_o, pin_oe;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    bitbang_port i_bitbang_port (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .dir_mask(dir_mask),
        .rate_tick(rate_tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_data(ret_data), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // dir, pin_i, byte written, expected returned byte (lock-step mode)
    localparam int NVEC = 8;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'hFF, 8'h00, 8'h55, 8'hFF},
        {8'hFF, 8'h00, 8'hAA, 8'h55},
        {8'hFF, 8'h00, 8'hAA, 8'hAA},
        {8'h0F, 8'hA0, 8'h3C, 8'hAA},
        {8'hF0, 8'h05, 8'hC3, 8'h35},
        {8'h00, 8'h9E, 8'h11, 8'h9E},
        {8'h81, 8'h7E, 8'hE7, 8'h7F},
        {8'hFF, 8'h00, 8'h00, 8'hE7}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        settle(2);
        // R1
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_o", pin_o, 8'hFF);
        check("R1 ret_valid", {7'd0, ret_valid}, 8'h00);
        check("R1 cmd_ready", {7'd0, cmd_ready}, 8'h00);
        rst_n = 1'b1;

        // R2: unknown code 0x02 keeps the port off
        mode_code = 8'h02; dir_mask = 8'hFF; cmd_valid = 1'b1; cmd_data = 8'h12; rate_tick = 1'b1;
        settle(3);
        check("R2 off ready", {7'd0, cmd_ready}, 8'h00);
        check("R2 off oe", pin_oe, 8'h00);
        check("R2 off latch", pin_o, 8'hFF);
        cmd_valid = 1'b0; rate_tick = 1'b0;

        // lock-step vector table (R6 R7 R8 R3)
        mode_code = 8'h04;
        settle(2);
        for (int v = 0; v < NVEC; v++) begin
            dir_mask = VEC[v][31:24];
            pin_i    = VEC[v][23:16];
            settle(3);
            check("R3 oe", pin_oe, VEC[v][31:24]);
            check("R6 ready", {7'd0, cmd_ready}, 8'h01);
            cmd_data = VEC[v][15:8]; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R6 pin_o", pin_o, VEC[v][15:8]);
            check("R8 ret_valid", {7'd0, ret_valid}, 8'h01);
            check("R7 ret_data", ret_data, VEC[v][7:0]);
            @(negedge clk);
            check("R8 single return", {7'd0, ret_valid}, 8'h00);
        end

        // R9: back-pressure
        dir_mask = 8'hFF; ret_ready = 1'b0;
        cmd_data = 8'h81; cmd_valid = 1'b1;
        @(negedge clk);
        check("R9 first ret", ret_data, 8'h00);
        cmd_data = 8'h42;
        settle(3);
        check("R9 ready low", {7'd0, cmd_ready}, 8'h00);
        check("R9 pins held", pin_o, 8'h81);
        check("R8 ret held", ret_data, 8'h00);
        check("R8 valid held", {7'd0, ret_valid}, 8'h01);
        ret_ready = 1'b1;
        @(negedge clk);
        check("R9 resumed pin", pin_o, 8'h42);
        check("R7 resumed ret", ret_data, 8'h81);
        cmd_valid = 1'b0;
        settle(2);

        // R4 R10 paced mode
        mode_code = 8'h01;
        settle(2);
        cmd_data = 8'h5A; cmd_valid = 1'b1; rate_tick = 1'b0;
        settle(3);
        check("R4 no tick ready", {7'd0, cmd_ready}, 8'h00);
        check("R5 hold", pin_o, 8'h42);
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0; cmd_valid = 1'b0;
        check("R4 pin_o", pin_o, 8'h5A);
        check("R10 no ret", {7'd0, ret_valid}, 8'h00);
        settle(3);
        check("R5 hold after", pin_o, 8'h5A);
        check("R10 still no ret", {7'd0, ret_valid}, 8'h00);

        // R11: mode change keeps latch
        mode_code = 8'h04;
        settle(2);
        check("R11 latch kept", pin_o, 8'h5A);
        cmd_data = 8'h00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 ret prior", ret_data, 8'h5A);
        settle(2);

        // R2: back to off disables outputs
        mode_code = 8'h00;
        settle(2);
        check("R2 oe off", pin_oe, 8'h00);
        check("R11 latch after off", pin_o, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule